// File: doc/BRIEF.md
# Row/Column Multiplexed DRAM Access Sequencer

This controller connects a one-request-at-a-time word interface to a single DRAM device that stores 2^ADDR_W one-bit cells. Each request address is split in two. The upper half selects a row and the lower half selects a column. Both halves leave the block on one shared bus that is ADDR_W/2 bits wide. The block then generates the row strobe, the column strobe and the write strobe in the correct order. Every phase length is a parameter counted in clock cycles: row-to-column delay, column strobe width and precharge.

A request is a single read, a single write, or a four-beat nibble burst. In a burst the row and the column are given once. The column strobe then pulses four times, and the two low column bits step through the four values modulo four, starting from the requested column. Read bits come back one per column pulse on a response strobe.

A free-running interval timer raises a refresh demand on its own. The sequencer serves that demand only while no access is running, and it serves it ahead of any waiting request. A refresh strobes only the row, using an internal row counter that advances after each refresh.

Top module: `dram_mux_ctrl`

## Requirements
- R1: For an access to address A, the bus carries A[ADDR_W-1:ADDR_W/2] (row) when the row strobe rises, and the column value when the column strobe rises. All strobes are active high (1 = asserted).
- R2: Every access asserts the row strobe with the column strobe low for exactly TRAS cycles before the first column strobe. The column strobe is never high while the row strobe is low.
- R3: During a read, the write strobe stays 0. Each read beat returns the bit stored at the strobed row and column on rsp_bit, with rsp_valid high for one cycle.
- R4: During a write, the write strobe is 1 together with the column strobe. dram_din carries req_wdata[k] for beat k (bit 0 for a single write), and that bit is stored at the strobed location.
- R5: A burst (req_burst=1) produces exactly four column pulses in one row pulse. For base column C, the columns are {C[hi:2], (C[1:0]+k) mod 4} for k=0..3. A non-burst access produces exactly one column pulse.
- R6: After every row strobe pulse, the row strobe stays low for at least TPRE cycles before it rises again.
- R7: A refresh raises the row strobe for TRAS cycles with no column pulse. Its row comes from a counter that starts at 0 after reset and increments modulo 2^(ADDR_W/2) after each refresh.
- R8: A refresh demand is raised every REFRESH_PERIOD cycles. A demand that is pending when the sequencer is idle is served before a valid request, so refreshes are never starved by continuous traffic.
- R9: Every column strobe pulse is high for exactly TCAS cycles.
- R10: req_ready is 1 only while the sequencer is idle with no refresh demand. A request is taken when req_valid and req_ready are both 1, and req_ready stays 0 until that access has finished. After reset, req_ready is 1 and all strobes and rsp_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-beat nibble burst |
| req_addr | input | ADDR_W | Cell address, row in the upper half |
| req_wdata | input | 4 | Write bits, bit k for beat k |
| rsp_valid | output | 1 | One read bit is available |
| rsp_bit | output | 1 | Read bit |
| dram_addr | output | ADDR_W/2 | Shared row/column address bus |
| dram_ras | output | 1 | Row strobe, active high |
| dram_cas | output | 1 | Column strobe, active high |
| dram_we | output | 1 | Write strobe, active high |
| dram_din | output | 1 | Data to the device |
| dram_dout | input | 1 | Data from the device, valid during a read column pulse |

## Verification
The assertions assume three things about the inputs:
- req_valid and its fields stay steady until req_ready takes them.
- The device holds dram_dout steady across the whole read column pulse.
- The timing parameters are each at least 1.

The stimulus changes request fields only just after a clock edge, and lowers req_valid once the request is taken. The behavioural device model in the bench drives its data output from the middle of the first column cycle, and it updates it only when a strobe changes. Traffic includes back-to-back requests with no idle cycles, so refresh demands are forced to meet requests that are already waiting.

// File: rtl/dram_ctrl_pkg.sv
// Shared types for the multiplexed DRAM sequencer.
// Assumes nothing beyond a SystemVerilog-2017 compiler.
package dram_ctrl_pkg;

    // Sequencer phases.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_GAP,
        ST_REF,
        ST_PRE
    } seq_state_e;

    // Source of the shared address bus.
    typedef enum logic [1:0] {
        SEL_ROW,
        SEL_COL,
        SEL_REF
    } addr_sel_e;

endpackage

// File: rtl/dram_refresh_timer.sv
// Interval timer that raises a refresh demand every PERIOD clocks.
// The demand stays up until the sequencer acknowledges it.
// Assumes PERIOD >= 2.
module dram_refresh_timer #(
    parameter int unsigned PERIOD = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = (cnt == CW'(PERIOD - 1));

    // Free-running interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // Demand flag: a new tick wins over an acknowledge in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    pending <= 1'b0;
        else if (tick) pending <= 1'b1;
        else if (ack)  pending <= 1'b0;
    end

endmodule

// File: rtl/dram_addr_mux.sv
// Drives the shared half-width address bus with the row, the column or
// the refresh row. It also holds the refresh row counter.
// Nibble beats change only the two low column bits, modulo four.
// Assumes ADDR_W is even and ADDR_W >= 4.
module dram_addr_mux
    import dram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  addr_sel_e                sel,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [1:0]               beat,
    input  logic                     ref_inc,
    output logic [ADDR_W/2-1:0]      bus
);
    localparam int unsigned HALF = ADDR_W / 2;

    logic [HALF-1:0] ref_row;
    logic [HALF-1:0] col;
    logic [1:0]      col_lo;

    assign col_lo = addr[1:0] + beat;

    // Upper column bits, when present, are held for the whole burst.
    generate
        if (HALF > 2) begin : g_wide_col
            assign col = {addr[HALF-1:2], col_lo};
        end else begin : g_narrow_col
            assign col = col_lo;
        end
    endgenerate

    // Refresh row counter; it wraps naturally at 2^HALF.
    always_ff @(posedge clk) begin
        if (!rst_n)       ref_row <= '0;
        else if (ref_inc) ref_row <= ref_row + 1'b1;
    end

    // Bus source selection.
    always_comb begin
        case (sel)
            SEL_COL: bus = col;
            SEL_REF: bus = ref_row;
            default: bus = addr[ADDR_W-1:HALF];
        endcase
    end

endmodule

// File: rtl/dram_seq_fsm.sv
// Phase sequencer. It takes one request, or one refresh demand, at a time,
// and times the row, column, gap and precharge phases with one shared
// down-counter. The strobes are decoded from the phase.
// Read data is sampled at the last cycle of each column pulse.
// Assumes TRAS, TCAS and TPRE >= 1.
module dram_seq_fsm
    import dram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned TRAS   = 2,
    parameter int unsigned TCAS   = 2,
    parameter int unsigned TPRE   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_pending,
    output logic              ref_ack,
    output logic              ref_inc,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_burst,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_wdata,
    input  logic              dram_dout,
    output addr_sel_e         addr_sel,
    output logic [1:0]        beat,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              dram_ras,
    output logic              dram_cas,
    output logic              dram_we,
    output logic              dram_din,
    output logic              rsp_valid,
    output logic              rsp_bit
);
    localparam int unsigned MAXT = (TRAS > TCAS) ? ((TRAS > TPRE) ? TRAS : TPRE)
                                                 : ((TCAS > TPRE) ? TCAS : TPRE);
    localparam int unsigned CNT_W = $clog2(MAXT + 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             cnt_done;
    logic             lat_wr;
    logic             lat_burst;
    logic [3:0]       lat_wdata;

    assign cnt_done = (cnt == '0);

    // Phase transitions, phase timing, request capture and read sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            beat      <= '0;
            lat_addr  <= '0;
            lat_wr    <= 1'b0;
            lat_burst <= 1'b0;
            lat_wdata <= '0;
            rsp_valid <= 1'b0;
            rsp_bit   <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (ref_pending) begin
                        state <= ST_REF;
                        cnt   <= CNT_W'(TRAS - 1);
                    end else if (req_valid) begin
                        state     <= ST_ROW;
                        cnt       <= CNT_W'(TRAS - 1);
                        beat      <= '0;
                        lat_addr  <= req_addr;
                        lat_wr    <= req_write;
                        lat_burst <= req_burst;
                        lat_wdata <= req_wdata;
                    end
                end
                ST_ROW: begin
                    if (cnt_done) begin
                        state <= ST_COL;
                        cnt   <= CNT_W'(TCAS - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_COL: begin
                    if (cnt_done) begin
                        if (!lat_wr) begin
                            rsp_valid <= 1'b1;
                            rsp_bit   <= dram_dout;
                        end
                        if (lat_burst && beat != 2'd3) begin
                            state <= ST_GAP;
                        end else begin
                            state <= ST_PRE;
                            cnt   <= CNT_W'(TPRE - 1);
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_GAP: begin
                    state <= ST_COL;
                    beat  <= beat + 1'b1;
                    cnt   <= CNT_W'(TCAS - 1);
                end
                ST_REF: begin
                    if (cnt_done) begin
                        state <= ST_PRE;
                        cnt   <= CNT_W'(TPRE - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_PRE: begin
                    if (cnt_done) state <= ST_IDLE;
                    else          cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Handshake, refresh control and strobe decode.
    always_comb begin
        req_ready = (state == ST_IDLE) && !ref_pending;
        ref_ack   = (state == ST_IDLE) && ref_pending;
        ref_inc   = (state == ST_REF) && cnt_done;
        dram_ras  = (state == ST_ROW) || (state == ST_COL) ||
                    (state == ST_GAP) || (state == ST_REF);
        dram_cas  = (state == ST_COL);
        dram_we   = (state == ST_COL) && lat_wr;
        dram_din  = lat_wr ? lat_wdata[beat] : 1'b0;
        case (state)
            ST_COL, ST_GAP: addr_sel = SEL_COL;
            ST_REF:         addr_sel = SEL_REF;
            default:        addr_sel = SEL_ROW;
        endcase
    end

    // R2: a column pulse only ever happens inside a row pulse.
    a_r2_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
        dram_cas |-> dram_ras);

    // R3: the write strobe is never raised outside a column pulse.
    a_r3_we_only_with_cas: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas |-> !dram_we);

    // R8: an idle refresh demand beats a waiting request.
    a_r8_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ref_pending && req_valid) |=> (state == ST_REF));

    // R10: an accepted request closes the handshake on the next cycle.
    a_r10_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/dram_mux_ctrl.sv
// Top of the multiplexed-address DRAM controller. It joins the refresh
// timer, the phase sequencer and the address multiplexer.
// Assumes one external DRAM device of 2^ADDR_W x 1 bit, with ADDR_W even.
module dram_mux_ctrl
    import dram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W         = 8,
    parameter int unsigned TRAS           = 2,
    parameter int unsigned TCAS           = 2,
    parameter int unsigned TPRE           = 2,
    parameter int unsigned REFRESH_PERIOD = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic                req_burst,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [3:0]          req_wdata,
    output logic                rsp_valid,
    output logic                rsp_bit,
    output logic [ADDR_W/2-1:0] dram_addr,
    output logic                dram_ras,
    output logic                dram_cas,
    output logic                dram_we,
    output logic                dram_din,
    input  logic                dram_dout
);
    localparam int unsigned PC_W = $clog2(TPRE + 2);

    logic              ref_pending;
    logic              ref_ack;
    logic              ref_inc;
    addr_sel_e         addr_sel;
    logic [1:0]        beat;
    logic [ADDR_W-1:0] lat_addr;
    logic [PC_W-1:0]   pre_cnt;

    dram_refresh_timer #(.PERIOD(REFRESH_PERIOD)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .pending (ref_pending)
    );

    dram_seq_fsm #(
        .ADDR_W (ADDR_W),
        .TRAS   (TRAS),
        .TCAS   (TCAS),
        .TPRE   (TPRE)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_pending (ref_pending),
        .ref_ack     (ref_ack),
        .ref_inc     (ref_inc),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_burst   (req_burst),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .dram_dout   (dram_dout),
        .addr_sel    (addr_sel),
        .beat        (beat),
        .lat_addr    (lat_addr),
        .dram_ras    (dram_ras),
        .dram_cas    (dram_cas),
        .dram_we     (dram_we),
        .dram_din    (dram_din),
        .rsp_valid   (rsp_valid),
        .rsp_bit     (rsp_bit)
    );

    dram_addr_mux #(.ADDR_W(ADDR_W)) u_amux (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (addr_sel),
        .addr    (lat_addr),
        .beat    (beat),
        .ref_inc (ref_inc),
        .bus     (dram_addr)
    );

    // Checker: row-strobe low time, saturating at TPRE.
    always_ff @(posedge clk) begin
        if (!rst_n)              pre_cnt <= PC_W'(TPRE);
        else if (dram_ras)       pre_cnt <= '0;
        else if (pre_cnt < PC_W'(TPRE)) pre_cnt <= pre_cnt + 1'b1;
    end

    // R6: the row strobe rises only after a full precharge.
    a_r6_precharge_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras) |-> (pre_cnt >= PC_W'(TPRE)));

endmodule

// File: tb/dram_mux_ctrl_tb.sv
`timescale 1ns/1ps
module dram_mux_ctrl_tb;
    localparam int AW   = 8;
    localparam int HW   = AW / 2;
    localparam int TRAS = 2;
    localparam int TCAS = 2;
    localparam int TPRE = 2;
    localparam int RPER = 64;
    localparam int REF_SLACK = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic          req_burst = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_wdata = '0;
    logic          rsp_valid;
    logic          rsp_bit;
    logic [HW-1:0] dram_addr;
    logic          dram_ras;
    logic          dram_cas;
    logic          dram_we;
    logic          dram_din;
    logic          dram_dout = 1'bz;

    dram_mux_ctrl #(.ADDR_W(AW), .TRAS(TRAS), .TCAS(TCAS), .TPRE(TPRE),
                    .REFRESH_PERIOD(RPER)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_bit(rsp_bit),
        .dram_addr(dram_addr), .dram_ras(dram_ras), .dram_cas(dram_cas),
        .dram_we(dram_we), .dram_din(dram_din), .dram_dout(dram_dout)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic          wr;
        logic          bu;
        logic [AW-1:0] addr;
        logic [3:0]    wd;
    } req_t;

    req_t   rq[$];
    logic   exp_rsp[$];
    logic   exp_mem[0:(1<<AW)-1];
    logic   dev_mem[0:(1<<AW)-1];
    int     checks = 0;
    int     errors = 0;
    int     cyc = 0;

    // Monitor state.
    logic          prev_ras = 1'b0, prev_cas = 1'b0, cas_seen = 1'b0, busy = 1'b0;
    logic          first_ras = 1'b1;
    logic [HW-1:0] cur_row = '0, dev_col = '0, exp_ref_row = '0;
    int            row_cnt = 0, cas_w = 0, pre_cnt = 0, beats = 0;
    int            last_ref = 0, ref_count = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Device model and cycle-by-cycle protocol reference.
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) check(!req_ready, "R10 ready while busy", req_ready, 0);
            if (req_valid && req_ready) busy = 1'b1;
            if (!dram_ras) check(!dram_cas && !dram_we, "R2/R3 strobes with RAS low",
                                 {dram_cas, dram_we}, 0);
            if (dram_ras && !prev_ras) begin
                if (!first_ras) check(pre_cnt >= TPRE, "R6 precharge", pre_cnt, TPRE);
                first_ras = 1'b0;
                cur_row = dram_addr; row_cnt = 0; cas_seen = 1'b0; beats = 0;
            end
            if (dram_ras && !dram_cas && !cas_seen) row_cnt++;
            if (dram_cas && !prev_cas) begin
                dev_col = dram_addr;
                if (rq.size() == 0) begin
                    check(0, "R10 column pulse without request", 1, 0);
                end else begin
                    logic [1:0]    lo;
                    logic [HW-1:0] ec;
                    lo = rq[0].addr[1:0] + 2'(beats);
                    ec = {rq[0].addr[HW-1:2], lo};
                    if (beats == 0) begin
                        check(row_cnt == TRAS, "R2 row-to-column delay", row_cnt, TRAS);
                        check(cur_row == rq[0].addr[AW-1:HW], "R1 row address",
                              cur_row, rq[0].addr[AW-1:HW]);
                    end
                    check(dram_addr == ec, "R1/R5 column address", dram_addr, ec);
                    check(dram_we == rq[0].wr, "R3/R4 write strobe", dram_we, rq[0].wr);
                    if (rq[0].wr)
                        check(dram_din == rq[0].wd[beats], "R4 write data",
                              dram_din, rq[0].wd[beats]);
                end
                if (dram_we) dev_mem[{cur_row, dev_col}] = dram_din;
                beats++; cas_seen = 1'b1; cas_w = 0;
            end
            if (dram_cas) cas_w++;
            if (!dram_cas && prev_cas) check(cas_w == TCAS, "R9 column pulse width", cas_w, TCAS);
            dram_dout = (dram_ras && dram_cas && !dram_we) ? dev_mem[{cur_row, dev_col}] : 1'bz;
            if (!dram_ras && prev_ras) begin
                if (!cas_seen) begin
                    check(cur_row == exp_ref_row, "R7 refresh row", cur_row, exp_ref_row);
                    check(row_cnt == TRAS, "R7 refresh pulse length", row_cnt, TRAS);
                    check((cyc - last_ref) <= RPER + REF_SLACK, "R8 refresh interval",
                          cyc - last_ref, RPER + REF_SLACK);
                    exp_ref_row = exp_ref_row + 1'b1;
                    last_ref = cyc; ref_count++;
                end else if (rq.size() > 0) begin
                    check(beats == (rq[0].bu ? 4 : 1), "R5 column pulse count",
                          beats, rq[0].bu ? 4 : 1);
                    void'(rq.pop_front());
                    busy = 1'b0;
                end
                pre_cnt = 0;
            end
            if (!dram_ras) pre_cnt++;
            if (rsp_valid) begin
                if (exp_rsp.size() == 0) check(0, "R3 unexpected response", 1, 0);
                else begin
                    logic e;
                    e = exp_rsp.pop_front();
                    check(rsp_bit === e, "R3 read data", rsp_bit, e);
                end
            end
            prev_ras = dram_ras; prev_cas = dram_cas;
        end
    end

    task automatic do_req(input logic wr, input logic bu, input logic [AW-1:0] a,
                          input logic [3:0] wd);
        req_t r;
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_burst = bu; req_addr = a; req_wdata = wd;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        r.wr = wr; r.bu = bu; r.addr = a; r.wd = wd;
        rq.push_back(r);
        for (int k = 0; k < (bu ? 4 : 1); k++) begin
            logic [1:0]    lo;
            logic [AW-1:0] ak;
            lo = a[1:0] + 2'(k);
            ak = {a[AW-1:2], lo};
            if (wr) exp_mem[ak] = wd[k];
            else    exp_rsp.push_back(exp_mem[ak]);
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (rq.size() != 0 || exp_rsp.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] x;
        for (int i = 0; i < (1 << AW); i++) begin exp_mem[i] = 1'b0; dev_mem[i] = 1'b0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R10 reset ready", req_ready, 1);
        check({dram_ras, dram_cas, dram_we, rsp_valid} == 4'b0, "R10 reset strobes",
              {dram_ras, dram_cas, dram_we, rsp_valid}, 0);
        // Single writes and reads (R1, R3, R4).
        do_req(1, 0, 8'hA5, 4'b0001);
        do_req(1, 0, 8'h5A, 4'b0001);
        do_req(1, 0, 8'hFF, 4'b0001);
        do_req(0, 0, 8'hA5, 4'b0);
        do_req(0, 0, 8'h5A, 4'b0);
        do_req(0, 0, 8'h00, 4'b0);
        // Bursts with wrapping base columns (R5).
        do_req(1, 1, 8'h3E, 4'b1011);
        do_req(0, 1, 8'h3F, 4'b0);
        do_req(0, 1, 8'h3C, 4'b0);
        do_req(1, 1, 8'hC1, 4'b0110);
        do_req(0, 0, 8'hC0, 4'b0);
        do_req(0, 1, 8'hC3, 4'b0);
        drain();
        // Quiet stretch: refresh alone (R7, R8).
        repeat (300) @(posedge clk);
        // Dense mixed traffic against refresh demands (R8).
        x = 32'h1234_5678;
        for (int n = 0; n < 120; n++) begin
            x = x * 32'd1103515245 + 32'd12345;
            do_req(x[20], x[21], x[31:24], x[15:12]);
        end
        drain();
        repeat (20) @(posedge clk);
        check(ref_count >= 4, "R8 refresh count", ref_count, 4);
        check(rq.size() == 0 && exp_rsp.size() == 0, "R10 all requests done",
              rq.size() + exp_rsp.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule